// File: doc/BRIEF.md
# Dual-Mode Timer with Countdown Watchdog

This block holds a pair of counters of width `W`: a low half and a high half. It can run them in three ways. In split mode they are two separate timers. In chained mode they form one counter of width `2*W`. In watchdog mode they form one countdown that software must service. Software programs the block through a simple write port, which holds the operating mode, two staged period values, a count source per half, an output style per half, and the enables.

In either timer mode a counter moves up by one on each tick. A tick is a clock cycle or a synchronised rising edge on that half's input pin. When the counter sits at its active period, the next tick returns it to zero and fires a one-cycle event. It also updates the half's output pin, which is either a copy of the event or a level that flips on every event. In watchdog mode the combined counter is loaded from the staged periods and counts down. Software must write a two-key sequence to reload it before it reaches zero. Once it reaches zero, a sticky expiry flag is raised.

Top module: `dual_timer`

## Requirements
- R1: After reset both counts are zero, and the events, output pins and expiry flag are all low.
- R2: Split mode (control bits [1:0] = 0). Each half with clock source counts 0,1,...,P and returns to 0, where P is its period register. The low half uses address 1 and the high half uses address 2, with enables at control bits 2 and 3. The half's event is high for one cycle in the same cycle its count returns to 0, so an event comes every P+1 cycles. The two halves are independent.
- R3: Chained mode (control bits [1:0] = 1, enable bit 2). {high count, low count} counts up to {high period, low period} with carry between the halves. The low event and low output fire on the wrap, and the high event and high output stay low.
- R4: With the source bit set (bit 4 for low, bit 5 for high), a half advances exactly once per rising edge of its input pin, after a two-flop synchroniser. A pin held high gives a single count.
- R5: With the style bit clear (bit 6 low, bit 7 high), the output pin equals the event. With the style bit set, the output pin flips on every event, starting from 0.
- R6: A period write while a half is running leaves the period in progress unchanged and takes effect from the next period.
- R7: Watchdog mode (control bits [1:0] = 2 with bit 2 set). The enabling write loads {high period, low period}. The count then falls by one per tick and stops at zero. The expiry flag rises one cycle after the count is seen at zero.
- R8: Writing key A and then key B, back to back to address 3, reloads the watchdog count from the period registers in the cycle of the key B write. Any other value between the keys, or key B on its own, does not reload.
- R9: Once watchdog mode is enabled, writes to the control register (address 0) are ignored until reset.
- R10: The expiry flag stays high until reset, even after a valid service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 low period, 2 high period, 3 service |
| wrData | input | W | Write data |
| pinLo | input | 1 | Count input pin of the low half |
| pinHi | input | 1 | Count input pin of the high half |
| cntLo | output | W | Low half count |
| cntHi | output | W | High half count |
| evtLo | output | 1 | Low half event pulse |
| evtHi | output | 1 | High half event pulse |
| outLo | output | 1 | Low half output pin |
| outHi | output | 1 | High half output pin |
| wdExpired | output | 1 | Sticky watchdog expiry flag |

## Verification
Both counts are visible at the ports, so a wrong counter value, a missed carry or a wrong reload shows in the very next sampled cycle. The bench compares the count against its arithmetic expectation on every cycle. Errors in the staged period or the key sequence stay hidden until the next wrap or service. The bench therefore follows each such write with at least one full period, and checks the event spacing and the count value at the point where the update must appear. A wrongly latched lock or expiry flag shows up as counting that continues or stops, at most one cycle after the write that should have changed it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_CHAIN = 2'd1,
    MODE_WDOG  = 2'd2
  } tmrMode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PRD_LO = 2'd1;
  localparam logic [1:0] ADDR_PRD_HI = 2'd2;
  localparam logic [1:0] ADDR_SVC    = 2'd3;

  // Strobes from control to datapath; index 0 = low half, 1 = high half
  typedef struct packed {
    tmrMode_e   mode;
    logic [1:0] run;
    logic [1:0] tick;
    logic [1:0] style;
    logic       wdStart;
    logic       wdReload;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] KEY_A = W'(32'h0000_C35A),
  parameter logic [W-1:0] KEY_B = W'(32'h0000_A53C)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [W-1:0]        wrData,
  input  logic [1:0]          pinIn,
  output tmrStrobe_t          strb,
  output logic [1:0][W-1:0]   prdQ
);

  localparam int SYNC_DEPTH = 3;

  tmrMode_e   modeQ;
  logic [1:0] enQ, srcQ, styleQ;
  logic       lockQ, armedQ;
  logic [1:0] rise;
  logic       ctrlWr, svcWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL) && !lockQ;
  assign svcWr  = wrEn && (wrAddr == ADDR_SVC);

  // Per-half pin synchroniser and rising-edge detector
  generate
    for (genvar h = 0; h < 2; h++) begin : g_sync
      logic [SYNC_DEPTH-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_DEPTH-2:0], pinIn[h]};
      end
      assign rise[h] = syncQ[SYNC_DEPTH-2] & ~syncQ[SYNC_DEPTH-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_SPLIT;
      enQ    <= '0;
      srcQ   <= '0;
      styleQ <= '0;
      lockQ  <= 1'b0;
      armedQ <= 1'b0;
      prdQ   <= '0;
    end else begin
      if (ctrlWr) begin
        modeQ  <= (wrData[1:0] == 2'd3) ? MODE_SPLIT : tmrMode_e'(wrData[1:0]);
        enQ    <= wrData[3:2];
        srcQ   <= wrData[5:4];
        styleQ <= wrData[7:6];
      end
      lockQ <= lockQ | strb.wdStart;
      if (svcWr) armedQ <= (wrData == KEY_A);
      for (int h = 0; h < 2; h++) begin
        if (wrEn && (wrAddr == ((h == 0) ? ADDR_PRD_LO : ADDR_PRD_HI)))
          prdQ[h] <= wrData;
      end
    end
  end

  always_comb begin
    strb.mode     = modeQ;
    strb.run[0]   = enQ[0];
    strb.run[1]   = enQ[1] && (modeQ == MODE_SPLIT);
    for (int h = 0; h < 2; h++)
      strb.tick[h] = srcQ[h] ? rise[h] : 1'b1;
    strb.style    = styleQ;
    strb.wdStart  = ctrlWr && (wrData[1:0] == 2'd2) && wrData[2];
    strb.wdReload = svcWr && armedQ && (wrData == KEY_B) &&
                    (modeQ == MODE_WDOG) && enQ[0];
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> (lockQ && $stable(modeQ) && enQ[0])); // R9
  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wdReload |-> lockQ); // R8

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [1:0][W-1:0] prdIn,
  output logic [1:0][W-1:0] cntQ,
  output logic [1:0]        evtQ,
  output logic [1:0]        outQ,
  output logic              expQ
);

  localparam int DW = 2 * W;

  logic [1:0][W-1:0] actQ;
  logic [DW-1:0]     cntAll, actAll;
  logic [1:0]        halfMatch, fire;
  logic              allMatch, isSplit, isChain, isWdog;

  assign cntAll   = cntQ;
  assign actAll   = actQ;
  assign allMatch = (cntAll == actAll);
  assign isSplit  = (strb.mode == MODE_SPLIT);
  assign isChain  = (strb.mode == MODE_CHAIN);
  assign isWdog   = (strb.mode == MODE_WDOG);

  always_comb begin
    for (int h = 0; h < 2; h++) halfMatch[h] = (cntQ[h] == actQ[h]);
    fire = '0;
    if (isChain)      fire[0] = strb.run[0] & strb.tick[0] & allMatch;
    else if (isSplit) fire    = strb.run & strb.tick & halfMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      actQ <= '0;
      evtQ <= '0;
      outQ <= '0;
      expQ <= 1'b0;
    end else begin
      evtQ <= fire;
      for (int h = 0; h < 2; h++) begin
        if (!strb.run[h] || isWdog) outQ[h] <= 1'b0;
        else if (strb.style[h])     outQ[h] <= outQ[h] ^ fire[h];
        else                        outQ[h] <= fire[h];
      end
      if (strb.wdStart) begin
        cntQ <= prdIn;
      end else if (isWdog) begin
        if (!strb.run[0] || strb.wdReload)          cntQ <= prdIn;
        else if (strb.tick[0] && (cntAll != '0))    cntQ <= cntAll - 1'b1;
        if (strb.run[0] && (cntAll == '0))          expQ <= 1'b1;
      end else if (isChain) begin
        if (!strb.run[0]) begin
          cntQ <= '0;
          actQ <= prdIn;
        end else if (strb.tick[0]) begin
          if (allMatch) begin
            cntQ <= '0;
            actQ <= prdIn;
          end else begin
            cntQ <= cntAll + 1'b1;
          end
        end
      end else begin
        for (int h = 0; h < 2; h++) begin
          if (!strb.run[h]) begin
            cntQ[h] <= '0;
            actQ[h] <= prdIn[h];
          end else if (strb.tick[h]) begin
            if (halfMatch[h]) begin
              cntQ[h] <= '0;
              actQ[h] <= prdIn[h];
            end else begin
              cntQ[h] <= cntQ[h] + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    expQ |=> expQ); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (isSplit && evtQ[0]) |-> (cntQ[0] == '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (isSplit && strb.run[0] && $past(isSplit && strb.run[0])) |-> (cntQ[0] <= actQ[0])); // R6
  AST_WD_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (isWdog && strb.run[0] &&
     $past(isWdog && strb.run[0] && !strb.wdReload && !strb.wdStart))
    |-> (cntAll <= $past(cntAll))); // R7

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] KEY_A = W'(32'h0000_C35A),
  parameter logic [W-1:0] KEY_B = W'(32'h0000_A53C)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         pinLo,
  input  logic         pinHi,
  output logic [W-1:0] cntLo,
  output logic [W-1:0] cntHi,
  output logic         evtLo,
  output logic         evtHi,
  output logic         outLo,
  output logic         outHi,
  output logic         wdExpired
);

  tmrStrobe_t        strb;
  logic [1:0][W-1:0] prd, cnt;
  logic [1:0]        evt, out;

  tmr_ctrl #(.W(W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .pinIn  ({pinHi, pinLo}),
    .strb   (strb),
    .prdQ   (prd)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .prdIn (prd),
    .cntQ  (cnt),
    .evtQ  (evt),
    .outQ  (out),
    .expQ  (wdExpired)
  );

  assign cntLo = cnt[0];
  assign cntHi = cnt[1];
  assign evtLo = evt[0];
  assign evtHi = evt[1];
  assign outLo = out[0];
  assign outHi = out[1];

endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;

  localparam int W = 8;
  localparam logic [W-1:0] KA = 8'hA5;
  localparam logic [W-1:0] KB = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic pinLo = 1'b0, pinHi = 1'b0;
  logic [W-1:0] cntLo, cntHi;
  logic evtLo, evtHi, outLo, outHi, wdExpired;

  int nChk = 0, nFail = 0, evSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_timer #(.W(W), .KEY_A(KA), .KEY_B(KB)) u_dual_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinLo(pinLo), .pinHi(pinHi), .cntLo(cntLo), .cntHi(cntHi),
    .evtLo(evtLo), .evtHi(evtHi), .outLo(outLo), .outHi(outHi),
    .wdExpired(wdExpired)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; exactly one posedge latches the write
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (evtLo) evSeen++;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic chkIdle(input string req);
    chk(req, {cntHi, cntLo}, 0);
    chk(req, {evtHi, evtLo, outHi, outLo, wdExpired}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    chkIdle("R1 reset");

    // R2: split mode sweep, both halves, clock source, pulse style (R5 pulse)
    for (int p = 0; p < 8; p++) begin
      int q = 7 - p;
      wr(2'd0, 8'h00);
      wr(2'd1, W'(p));
      wr(2'd2, W'(q));
      wr(2'd0, 8'h0C);
      for (int i = 1; i <= 24; i++) begin
        @(negedge clk);
        chk("R2 cntLo", cntLo, i % (p + 1));
        chk("R2 evtLo", evtLo, (i % (p + 1)) == 0);
        chk("R2 cntHi", cntHi, i % (q + 1));
        chk("R2 evtHi", evtHi, (i % (q + 1)) == 0);
        chk("R5 pulse outLo", outLo, evtLo);
      end
    end

    // R5: toggle style on low half, period 2
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h44);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R5 toggle outLo", outLo, (i / 3) % 2);
      chk("R5 evtLo", evtLo, (i % 3) == 0);
    end

    // R3: chained, period {1,3} = 259, carry between halves
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h05);
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      chk("R3 count64", {cntHi, cntLo}, i % 260);
      chk("R3 evtLo", evtLo, (i % 260) == 0);
      chk("R3 hi quiet", {evtHi, outHi}, 0);
    end

    // R6: live period change 5 -> 2 at count 2 of second period
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h04);
    repeat (8) @(negedge clk);
    wr(2'd1, 8'd2);
    for (int i = 10; i <= 24; i++) begin
      @(negedge clk);
      if (i <= 12) begin
        chk("R6 old period cnt", cntLo, i % 6);
        chk("R6 old period evt", evtLo, i == 12);
      end else begin
        chk("R6 new period cnt", cntLo, (i - 12) % 3);
        chk("R6 new period evt", evtLo, ((i - 12) % 3) == 0);
      end
    end

    // R4: pin source on low half, period 2
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h14);
    evSeen = 0;
    for (int k = 1; k <= 7; k++) begin
      pinLo = 1'b1; tick(3);
      pinLo = 1'b0; tick(3);
      chk("R4 pin count", cntLo, k % 3);
    end
    pinLo = 1'b1; tick(10);
    pinLo = 1'b0; tick(10);
    chk("R4 long high one count", cntLo, 8 % 3);
    chk("R4 event count", evSeen, 2);
    chk("R4 hi idle", cntHi, 0);

    // R7..R10: watchdog
    doReset();
    chkIdle("R1 reset again");
    wr(2'd1, 8'd10);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h06);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R7 countdown", {cntHi, cntLo}, 10 - i);
    end
    wr(2'd3, KA);
    chk("R7 countdown during key A", {cntHi, cntLo}, 4);
    wr(2'd3, KB);
    chk("R8 reload on key pair", {cntHi, cntLo}, 10);
    wr(2'd3, KA);
    wr(2'd3, 8'h33);
    wr(2'd3, KB);
    chk("R8 broken sequence no reload", {cntHi, cntLo}, 7);
    wr(2'd3, KB);
    chk("R8 lone key B no reload", {cntHi, cntLo}, 6);
    wr(2'd0, 8'h0C);
    chk("R9 ctrl write ignored", {cntHi, cntLo}, 5);
    tick(1);
    chk("R9 still counting down", {cntHi, cntLo}, 4);
    chk("R9 no timer events", {evtHi, evtLo}, 0);
    wr(2'd1, 8'd3);
    chk("R7 countdown after period write", {cntHi, cntLo}, 3);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chk("R7 count floor", {cntHi, cntLo}, (3 - j > 0) ? 3 - j : 0);
      chk("R7 expiry", wdExpired, j >= 4);
    end
    wr(2'd3, KA);
    wr(2'd3, KB);
    chk("R10 reload after expiry", {cntHi, cntLo}, 3);
    chk("R10 sticky after service", wdExpired, 1);
    tick(2);
    chk("R10 sticky", wdExpired, 1);

    doReset();
    chkIdle("R1 final reset");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule